// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

The bridge places the register set of one IDE channel inside a 4096-byte window of a big-endian host bus. Each register sits on its own 16-byte slot: the slot number is taken from address bits 11 down to 4. Byte accesses reach the seven task-file registers and the device-control / alternate-status pair. Halfword and word accesses reach the data port. The device speaks little-endian, so the bridge reverses the byte order of data-port traffic in both directions.

Each host access is a single-cycle request. The strobes toward the device fire combinationally in the request cycle, and the device returns the selected register value on `ide_rdata` in that same cycle. The bridge registers the read result and presents it together with a one-cycle `bus_rvalid` on the following cycle. A read of the status register also pulses an acknowledge so the device can drop its pending interrupt. The alternate-status copy is read with no side effect.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The slot index is `bus_addr[11:4]`. Address bits above bit 11 and bits 3:0 have no effect on decoding.
- R2: A byte access (`bus_size`=0) to slot 1..7 pulses `ide_rd_tf` (read) or `ide_wr_tf` (write), with `ide_reg` equal to the slot number. A write carries `bus_wdata[7:0]` on `ide_wdata[7:0]`. A read returns `{24'h0, ide_rdata[7:0]}`.
- R3: A byte write to slot 8 or slot 22 pulses `ide_wr_ctl` and carries `bus_wdata[7:0]` on `ide_wdata[7:0]`.
- R4: A byte read from slot 8 or slot 22 raises `ide_sel_alt` and returns `{24'h0, ide_rdata[7:0]}`. It raises neither `ide_rd_tf` nor `ide_irq_ack`.
- R5: A byte read from any other slot returns 32'h000000FF. A byte write there raises no device strobe.
- R6: A halfword (`bus_size`=1) or word (`bus_size`=2 or 3) access to slot 0 pulses `ide_rd_data` or `ide_wr_data`; `ide_wide` is 1 for a word.
  - On writes, the bytes of `bus_wdata[15:0]` (halfword) or `bus_wdata[31:0]` (word) are reversed onto `ide_wdata`.
  - On reads, the bytes of `ide_rdata` are reversed in the same way, and the upper half is zero for a halfword.
- R7: A halfword read from a non-zero slot returns 32'h0000FFFF and a word read returns 32'hFFFFFFFF. Writes to those slots raise no device strobe.
- R8: A byte read from slot 7 (status) pulses `ide_irq_ack` for exactly the request cycle, together with `ide_rd_tf`.
- R9: Read data and `bus_rvalid` appear one cycle after a read request, for every size. `bus_rvalid` is low after a write or an idle cycle. After reset, `bus_rdata` is 0 and `bus_rvalid` is 0.
- R10: At most one of `ide_rd_tf`, `ide_wr_tf`, `ide_wr_ctl`, `ide_sel_alt`, `ide_rd_data`, `ide_wr_data` is high in a cycle. None is high, and neither is `ide_irq_ack`, while `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_addr | input | ADDR_W | Byte address; only the window bits are decoded |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_we | input | 1 | 1 write, 0 read |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| ide_reg | output | 3 | Task-file register number, 0 when no task-file access |
| ide_rd_tf | output | 1 | Task-file read strobe |
| ide_wr_tf | output | 1 | Task-file write strobe |
| ide_wr_ctl | output | 1 | Device-control write strobe |
| ide_sel_alt | output | 1 | Alternate-status select, no side effect |
| ide_irq_ack | output | 1 | Status-read pulse that clears the device interrupt |
| ide_rd_data | output | 1 | Data-port read strobe |
| ide_wr_data | output | 1 | Data-port write strobe |
| ide_wide | output | 1 | Data-port access is 32 bits |
| ide_wdata | output | 32 | Write data toward the device |
| ide_rdata | input | 32 | Register value from the device, same cycle |

## Verification
The assertions check three things on every cycle. First, the read-response timing and the quiet response after writes. Second, the exclusivity of the device strobes and their silence while idle. Third, the all-ones answers for unmapped slots of each size and the tie of the interrupt acknowledge to a status read.

Some behaviour only the bench's sweep can show: that every one of the 256 slots under every size and direction decodes to the right target, that both control aliases work, and that byte reversal places each lane correctly. The bench also shows that upper and lower address bits are truly ignored and that write data reaches the device unaltered in the right lanes.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rsp_t;

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode #(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int TF_LAST     = 7,
    parameter int CTL_SLOT_A  = 8,
    parameter int CTL_SLOT_B  = 22,
    localparam int IDX_W      = WIN_BITS - STRIDE_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  idx,
    output logic              is_tf,
    output logic              is_ctl,
    output logic              is_data,
    output logic              is_wide
);
    import ide_bridge_pkg::*;

    logic unused_addr_bits;
    logic is_byte;

    assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_BITS], addr[STRIDE_BITS-1:0]};

    always_comb begin
        idx     = addr[WIN_BITS-1:STRIDE_BITS];
        is_byte = (size == SZ_BYTE);
        is_wide = (size != SZ_BYTE) && (size != SZ_HALF);
        is_tf   = is_byte && (idx >= IDX_W'(1)) && (idx <= IDX_W'(TF_LAST));
        is_ctl  = is_byte && ((idx == IDX_W'(CTL_SLOT_A)) || (idx == IDX_W'(CTL_SLOT_B)));
        is_data = !is_byte && (idx == '0);
    end

endmodule

// File: rtl/ide_lane_swap.sv
module ide_lane_swap #(
    parameter int BYTES = 4,
    localparam int W    = 8 * BYTES
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge #(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int STATUS_SLOT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [2:0]        ide_reg,
    output logic              ide_rd_tf,
    output logic              ide_wr_tf,
    output logic              ide_wr_ctl,
    output logic              ide_sel_alt,
    output logic              ide_irq_ack,
    output logic              ide_rd_data,
    output logic              ide_wr_data,
    output logic              ide_wide,
    output logic [31:0]       ide_wdata,
    input  logic [31:0]       ide_rdata
);
    import ide_bridge_pkg::*;

    localparam int IDX_W = WIN_BITS - STRIDE_BITS;

    logic [IDX_W-1:0] idx;
    logic is_tf, is_ctl, is_data, is_wide;
    logic rd_req, wr_req;
    logic [15:0] wr_half_sw, rd_half_sw;
    logic [31:0] wr_word_sw, rd_word_sw;
    rsp_t rsp_d, rsp_q;

    ide_win_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
        .TF_LAST(STATUS_SLOT), .CTL_SLOT_A(8), .CTL_SLOT_B(22)
    ) u_dec (
        .addr(bus_addr), .size(bus_size), .idx(idx),
        .is_tf(is_tf), .is_ctl(is_ctl), .is_data(is_data), .is_wide(is_wide)
    );

    ide_lane_swap #(.BYTES(2)) u_sw_wh (.din(bus_wdata[15:0]), .dout(wr_half_sw));
    ide_lane_swap #(.BYTES(4)) u_sw_ww (.din(bus_wdata),       .dout(wr_word_sw));
    ide_lane_swap #(.BYTES(2)) u_sw_rh (.din(ide_rdata[15:0]), .dout(rd_half_sw));
    ide_lane_swap #(.BYTES(4)) u_sw_rw (.din(ide_rdata),       .dout(rd_word_sw));

    // device-side strobes: combinational, live only in the request cycle
    always_comb begin
        rd_req      = bus_req && !bus_we;
        wr_req      = bus_req && bus_we;
        ide_rd_tf   = rd_req && is_tf;
        ide_wr_tf   = wr_req && is_tf;
        ide_wr_ctl  = wr_req && is_ctl;
        ide_sel_alt = rd_req && is_ctl;
        ide_rd_data = rd_req && is_data;
        ide_wr_data = wr_req && is_data;
        ide_irq_ack = rd_req && is_tf && (idx == IDX_W'(STATUS_SLOT));
        ide_wide    = is_data && is_wide;
        ide_reg     = is_tf ? idx[2:0] : 3'd0;
        if (is_data)
            ide_wdata = is_wide ? wr_word_sw : {16'h0, wr_half_sw};
        else
            ide_wdata = {24'h0, bus_wdata[7:0]};
    end

    // next response
    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.rvalid = rd_req;
        if (rd_req) begin
            if (is_tf || is_ctl)
                rsp_d.rdata = {24'h0, ide_rdata[7:0]};
            else if (is_data)
                rsp_d.rdata = is_wide ? rd_word_sw : {16'h0, rd_half_sw};
            else if (bus_size == SZ_BYTE)
                rsp_d.rdata = 32'h0000_00FF;
            else if (bus_size == SZ_HALF)
                rsp_d.rdata = 32'h0000_FFFF;
            else
                rsp_d.rdata = 32'hFFFF_FFFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata  = rsp_q.rdata;
    assign bus_rvalid = rsp_q.rvalid;

endmodule

// File: rtl/ide_mmio_bridge_chk.sv
module ide_mmio_bridge_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [2:0]        ide_reg,
    input logic              ide_rd_tf,
    input logic              ide_wr_tf,
    input logic              ide_wr_ctl,
    input logic              ide_sel_alt,
    input logic              ide_irq_ack,
    input logic              ide_rd_data,
    input logic              ide_wr_data
);
    logic [7:0] slot;
    logic       slot_mapped_byte;
    assign slot = bus_addr[11:4];
    assign slot_mapped_byte = (slot >= 8'd1 && slot <= 8'd8) || slot == 8'd22;

    p_rvalid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |=> bus_rvalid);

    p_quiet_after_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ide_rd_tf, ide_wr_tf, ide_wr_ctl, ide_sel_alt, ide_rd_data, ide_wr_data}));

    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> !(ide_rd_tf || ide_wr_tf || ide_wr_ctl || ide_sel_alt
                       || ide_rd_data || ide_wr_data || ide_irq_ack));

    p_ack_on_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ide_irq_ack |-> ide_rd_tf && ide_reg == 3'd7);

    p_alt_no_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ide_sel_alt |-> !ide_irq_ack);

    p_unmapped_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_size == 2'd0 && !slot_mapped_byte
        |=> bus_rdata == 32'h0000_00FF);

    p_unmapped_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_size == 2'd1 && slot != 8'd0
        |=> bus_rdata == 32'h0000_FFFF);

    p_unmapped_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_size[1] && slot != 8'd0
        |=> bus_rdata == 32'hFFFF_FFFF);

endmodule

bind ide_mmio_bridge ide_mmio_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ide_mmio_bridge_tb.sv
module ide_mmio_bridge_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [2:0]  ide_reg;
    logic        ide_rd_tf, ide_wr_tf, ide_wr_ctl, ide_sel_alt, ide_irq_ack;
    logic        ide_rd_data, ide_wr_data, ide_wide;
    logic [31:0] ide_wdata, ide_rdata;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [7:0]  ALT_VAL  = 8'hA5;
    localparam logic [31:0] DATA_VAL = 32'h1122_3344;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] tf_val(input int i);
        return 8'(8'h30 + 8'(i) * 8'h0B);
    endfunction

    // device model: returns the selected register in the same cycle
    always_comb begin
        if (ide_sel_alt)      ide_rdata = {24'hFFFF00, ALT_VAL};
        else if (ide_rd_data) ide_rdata = DATA_VAL;
        else                  ide_rdata = {24'hEEEE00, tf_val(int'(ide_reg))};
    end

    ide_mmio_bridge u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] addr, input logic [1:0] size,
                          input logic we, input logic [31:0] wd, input string tag);
        int         idx;
        bit         byt, tf, ctl, dat, wide;
        logic [6:0] exp_s, act_s;
        logic [31:0] exp_w, exp_r;
        string      req;
        idx  = int'(addr[11:4]);
        byt  = (size == 2'd0);
        wide = size[1];
        tf   = byt && idx >= 1 && idx <= 7;
        ctl  = byt && (idx == 8 || idx == 22);
        dat  = !byt && idx == 0;
        if (tag != "")  req = tag;
        else if (tf)    req = (idx == 7 && !we) ? "R8" : "R2";
        else if (ctl)   req = we ? "R3" : "R4";
        else if (dat)   req = "R6";
        else if (byt)   req = "R5";
        else            req = "R7";

        @(negedge clk);
        bus_req = 1'b1; bus_addr = addr; bus_size = size; bus_we = we; bus_wdata = wd;
        #1;
        exp_s = {!we && tf, we && tf, we && ctl, !we && ctl, !we && dat, we && dat,
                 !we && tf && idx == 7};
        act_s = {ide_rd_tf, ide_wr_tf, ide_wr_ctl, ide_sel_alt, ide_rd_data,
                 ide_wr_data, ide_irq_ack};
        chk(act_s == exp_s, req, "strobes", 32'(act_s), 32'(exp_s));
        if (tf) chk(ide_reg == 3'(idx), req, "reg index", 32'(ide_reg), 32'(idx));
        if (we && (tf || ctl))
            chk(ide_wdata[7:0] == wd[7:0], req, "byte wdata", ide_wdata, {24'h0, wd[7:0]});
        if (dat) begin
            chk(ide_wide == wide, req, "wide flag", 32'(ide_wide), 32'(wide));
            if (we) begin
                exp_w = wide ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]}
                             : {16'h0, wd[7:0], wd[15:8]};
                chk(ide_wdata == exp_w, req, "swapped wdata", ide_wdata, exp_w);
            end
        end

        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        #1;
        chk(bus_rvalid == !we, "R9", "rvalid", 32'(bus_rvalid), 32'(!we));
        if (!we) begin
            if (tf)       exp_r = {24'h0, tf_val(idx)};
            else if (ctl) exp_r = {24'h0, ALT_VAL};
            else if (dat) exp_r = wide ? {DATA_VAL[7:0], DATA_VAL[15:8], DATA_VAL[23:16], DATA_VAL[31:24]}
                                       : {16'h0, DATA_VAL[7:0], DATA_VAL[15:8]};
            else if (byt) exp_r = 32'h0000_00FF;
            else if (size == 2'd1) exp_r = 32'h0000_FFFF;
            else          exp_r = 32'hFFFF_FFFF;
            chk(bus_rdata == exp_r, req, "rdata", bus_rdata, exp_r);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk(bus_rvalid == 1'b0, "R9", "reset rvalid", 32'(bus_rvalid), 32'h0);
        chk(bus_rdata == 32'h0, "R9", "reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 idle cycle: no strobe
        chk({ide_rd_tf, ide_wr_tf, ide_wr_ctl, ide_sel_alt, ide_rd_data, ide_wr_data,
             ide_irq_ack} == 7'h0, "R10", "idle strobes", 32'h0, 32'h0);

        // sweep all slots, sizes and directions
        for (int i = 0; i < 256; i++) begin
            for (int s = 0; s < 4; s++) begin
                for (int w = 0; w < 2; w++) begin
                    access({20'(i * 37 + s), 8'(i), 4'(i ^ s)}, 2'(s), 1'(w),
                           32'(32'hC0DE_0000 + i * 32'h0101 + s), "");
                end
            end
        end

        // R1: upper and lower address bits do not disturb decoding
        access(32'hFFFF_F07F, 2'd0, 1'b0, 32'h0, "R1");
        access(32'hABCD_E16C, 2'd0, 1'b1, 32'h0000_005C, "R1");
        access(32'h7654_300F, 2'd2, 1'b0, 32'h0, "R1");
        access(32'h0000_1003, 2'd1, 1'b1, 32'h0000_BEEF, "R1");

        // R9 back-to-back: rvalid falls again after the response cycle
        @(negedge clk); #1;
        chk(bus_rvalid == 1'b0, "R9", "rvalid one cycle", 32'(bus_rvalid), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule